// File: doc/BRIEF.md
# Posted Write Tracker With Error Log

This block follows every physical-memory write that the bus side has already acknowledged as complete but whose data has not yet reached host memory. A post request carries the requester's 16-bit source node ID and a 48-bit offset. If posting is enabled and a slot is free, the block grants that slot and returns a 2-bit tag. The slot then stays pending until the memory side reports a result for that tag. When all slots are pending the block refuses the request. The caller must then answer with a pending or busy acknowledgement and not a completed one.

Each slot keeps the identity of its write. When the memory side reports a failure, the block copies the slot's node ID and offset into that slot's error register and raises an interrupt. The error register keeps its contents until software writes the slot's clear bit. If a second failure arrives in a slot that has not been cleared, the register keeps the first failure and a sticky overflow flag is set.

The post request is a valid/ready handshake. A write is posted only in a cycle where `req_valid` and `req_ready` are both high. The caller may hold `req_valid` high for any length of time, and nothing is taken while `req_ready` is low. In a cycle of acceptance `grant_tag` is combinational and valid. Completion reports, the enable bit, the clear bits and the error read select are plain level signals with no back-pressure.

Top module: `posted_write_tracker`

## Requirements
- R1: After reset, `pending`, `err_valid` and `err_ovf` are all zero, and `full` and `irq` are low.
- R2: `req_ready` is high exactly when `post_en` is high and at least one slot is either free or being freed by a completion in the same cycle. A write is accepted when `req_valid` and `req_ready` are both high, and its slot's `pending` bit is set from the next cycle on.
- R3: The accepted write takes the lowest-numbered slot that is available, and `grant_tag` carries that slot's number (0 to 3).
- R4: At most four writes are pending. `full` is high while all four `pending` bits are set. In that state `req_ready` stays low unless a completion frees a slot in the same cycle.
- R5: A slot stays pending until a completion (`cpl_valid`) arrives with its tag, whether it reports success or failure. A completion whose tag is not pending changes nothing.
- R6: A failure completion (`cpl_fail` = 1) for a pending slot with no logged error sets that slot's `err_valid` bit in the next cycle. It also stores the slot's node ID and offset, which are read on `err_node`/`err_offset` when `err_sel` selects the slot, and it makes `irq` high.
- R7: An error register holds its contents while its `err_valid` bit is set and its clear bit is low. A further failure in that slot sets `err_ovf` for that slot and leaves the stored node ID and offset unchanged.
- R8: Writing 1 to bit i of `err_clr` clears `err_valid[i]` and `err_ovf[i]` in the next cycle. `irq` is low whenever no `err_valid` bit is set.
- R9: A completion that frees one slot and a grant of a different slot, or of that same slot, may happen in the same cycle. A slot that is freed and granted again in one cycle stays pending.
- R10: While `post_en` is low no write is accepted and no slot becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Software enable for posting |
| req_valid | input | 1 | Post request valid |
| req_ready | output | 1 | Post request can be accepted |
| req_node | input | 16 | Source node ID of the request |
| req_offset | input | 48 | Target offset of the request |
| grant_tag | output | 2 | Slot granted in the accepting cycle |
| full | output | 1 | All slots pending |
| pending | output | 4 | Per-slot pending flags |
| cpl_valid | input | 1 | Completion report valid |
| cpl_tag | input | 2 | Tag of the completed slot |
| cpl_fail | input | 1 | Completion reports a failed write |
| err_clr | input | 4 | Per-slot error clear strobes |
| err_valid | output | 4 | Per-slot logged error flags |
| err_ovf | output | 4 | Per-slot sticky overflow flags |
| err_sel | input | 2 | Error register read select |
| err_node | output | 16 | Node ID of the selected error register |
| err_offset | output | 48 | Offset of the selected error register |
| irq | output | 1 | Interrupt event, high while any error is logged |

## Verification
A slot whose pending flag is lost or left stuck shows up at once as a wrong `grant_tag` in the next accepted request, or as `full` and `req_ready` disagreeing with the count of outstanding writes. A mistake in capturing a request is seen only when that slot fails and software reads the register through `err_sel`. The bench therefore fails writes in several slots after those slots have been reused. It also checks that a second failure leaves the first logged values in place. One cycle after each completion or clear, the bench compares the error flags and `irq`.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int NODE_W = 16;
  localparam int OFF_W  = 48;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    logic [OFF_W-1:0]  offset;
  } pwt_rec_t;
endpackage

// File: rtl/pwt_alloc.sv
module pwt_alloc #(
  parameter int SLOTS = 4,
  localparam int TAG_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] avail,
  output logic             any_avail,
  output logic [TAG_W-1:0] tag,
  output logic [SLOTS-1:0] pick
);
  always_comb begin
    tag  = '0;
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) begin
        tag  = TAG_W'(i);
        pick = SLOTS'(1) << i;
      end
    end
  end

  assign any_avail = |avail;
endmodule

// File: rtl/pwt_slot.sv
module pwt_slot
  import pwt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     grant,
  input  pwt_rec_t req_rec,
  input  logic     done,
  input  logic     fail,
  input  logic     clr,
  output logic     pend_q,
  output logic     err_q,
  output logic     ovf_q,
  output pwt_rec_t err_rec
);
  pwt_rec_t req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (grant) begin
      pend_q <= 1'b1;
    end else if (done) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (grant) req_q <= req_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
      err_rec <= '0;
    end else if (done && fail) begin
      if (err_q && !clr) begin
        ovf_q <= 1'b1;
      end else begin
        err_q   <= 1'b1;
        ovf_q   <= 1'b0;
        err_rec <= req_q;
      end
    end else if (clr) begin
      err_q <= 1'b0;
      ovf_q <= 1'b0;
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr |=> err_q && $stable(err_rec)); // R7
  AST_OVF_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> err_q); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(done && fail) |=> !err_q && !ovf_q); // R8
endmodule

// File: rtl/posted_write_tracker.sv
module posted_write_tracker
  import pwt_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int TAG_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NODE_W-1:0] req_node,
  input  logic [OFF_W-1:0]  req_offset,
  output logic [TAG_W-1:0]  grant_tag,
  output logic              full,
  output logic [SLOTS-1:0]  pending,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic              cpl_fail,
  input  logic [SLOTS-1:0]  err_clr,
  output logic [SLOTS-1:0]  err_valid,
  output logic [SLOTS-1:0]  err_ovf,
  input  logic [TAG_W-1:0]  err_sel,
  output logic [NODE_W-1:0] err_node,
  output logic [OFF_W-1:0]  err_offset,
  output logic              irq
);
  logic [SLOTS-1:0] done_vec;
  logic [SLOTS-1:0] avail;
  logic [SLOTS-1:0] pick;
  logic [SLOTS-1:0] grant_vec;
  logic             any_avail;
  logic             req_fire;
  pwt_rec_t         req_rec;
  pwt_rec_t         err_arr [SLOTS];

  assign req_rec = '{node: req_node, offset: req_offset};

  always_comb begin
    done_vec = '0;
    if (cpl_valid) done_vec = (SLOTS'(1) << cpl_tag) & pending;
  end

  assign avail = ~pending | done_vec;

  pwt_alloc #(.SLOTS(SLOTS)) u_alloc (
    .avail     (avail),
    .any_avail (any_avail),
    .tag       (grant_tag),
    .pick      (pick)
  );

  assign req_ready = post_en && any_avail;
  assign req_fire  = req_valid && req_ready;
  assign grant_vec = req_fire ? pick : '0;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    pwt_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant_vec[g]),
      .req_rec (req_rec),
      .done    (done_vec[g]),
      .fail    (cpl_fail),
      .clr     (err_clr[g]),
      .pend_q  (pending[g]),
      .err_q   (err_valid[g]),
      .ovf_q   (err_ovf[g]),
      .err_rec (err_arr[g])
    );
  end

  assign full       = &pending;
  assign irq        = |err_valid;
  assign err_node   = err_arr[err_sel].node;
  assign err_offset = err_arr[err_sel].offset;

  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> !pending[grant_tag] || done_vec[grant_tag]); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !cpl_valid |-> !req_ready); // R4
  AST_FAIL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_fail && pending[cpl_tag] |=> irq); // R6
  AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> pending[$past(grant_tag)]); // R2
  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !post_en && !cpl_valid |=> $stable(pending)); // R10
  AST_STRAY_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !pending[cpl_tag] && !req_fire |=> $stable(pending)); // R5
endmodule

// File: tb/posted_write_tracker_tb.sv
`timescale 1ns/1ps
module posted_write_tracker_tb;
  localparam int SLOTS = 4;

  logic        clk = 1'b0;
  logic        rst_n, post_en, req_valid, req_ready, full, cpl_valid, cpl_fail, irq;
  logic [15:0] req_node, err_node;
  logic [47:0] req_offset, err_offset;
  logic [1:0]  grant_tag, cpl_tag, err_sel;
  logic [3:0]  pending, err_clr, err_valid, err_ovf;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  logic [3:0] m_pend = 4'b0;

  always #2.5 clk = ~clk;

  posted_write_tracker #(.SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_node(req_node), .req_offset(req_offset),
    .grant_tag(grant_tag), .full(full), .pending(pending),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_fail(cpl_fail),
    .err_clr(err_clr), .err_valid(err_valid), .err_ovf(err_ovf),
    .err_sel(err_sel), .err_node(err_node), .err_offset(err_offset), .irq(irq)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (req_valid && req_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL R4/R10 unexpected grant actual=%0d expected=none", grant_tag);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (int'(grant_tag) != e) begin
            n_err++;
            $display("FAIL R3 grant_tag actual=%0d expected=%0d", grant_tag, e);
          end
        end
      end else if (exp_q.size() != 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R2 missing grant actual=none expected=%0d", exp_q[0]);
        exp_q.delete();
      end
    end
  end

  task automatic step(input logic rv, input logic [15:0] nd, input logic [47:0] of,
                      input logic cv, input logic [1:0] ct, input logic cf,
                      input logic [3:0] clr);
    logic [3:0] fr;
    int t;
    @(posedge clk);
    #1;
    req_valid = rv; req_node = nd; req_offset = of;
    cpl_valid = cv; cpl_tag = ct; cpl_fail = cf; err_clr = clr;
    fr = ~m_pend;
    if (cv && m_pend[ct]) fr[ct] = 1'b1;
    t = -1;
    for (int i = SLOTS - 1; i >= 0; i--) if (fr[i]) t = i;
    if (rv && post_en && t >= 0) exp_q.push_back(t);
    @(negedge clk);
    if (cv && m_pend[ct]) m_pend[ct] = 1'b0;
    if (rv && post_en && t >= 0) m_pend[t] = 1'b1;
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 48'h0, 1'b0, 2'd0, 1'b0, 4'h0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; post_en = 1'b0; req_valid = 1'b0; req_node = '0; req_offset = '0;
    cpl_valid = 1'b0; cpl_tag = '0; cpl_fail = 1'b0; err_clr = '0; err_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", pending, 4'h0);
    chk("R1 full", full, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 err_valid", err_valid, 4'h0);
    chk("R1 err_ovf", err_ovf, 4'h0);

    post_en = 1'b1;
    step(1, 16'h00A1, 48'h0000_1000_0000, 0, 0, 0, 0);
    step(1, 16'h00B2, 48'h0000_2000_0040, 0, 0, 0, 0);
    step(1, 16'h00C3, 48'h1234_5678_9ABC, 0, 0, 0, 0);
    step(1, 16'h00D4, 48'h0000_4000_0080, 0, 0, 0, 0);
    idle();
    chk("R4 pending all", pending, 4'hF);
    chk("R4 full", full, 1'b1);
    step(1, 16'h00EE, 48'h0, 0, 0, 0, 0);
    chk("R4 ready low when full", req_ready, 1'b0);
    idle();

    step(0, 0, 0, 1, 2'd3, 0, 0);
    step(0, 0, 0, 1, 2'd1, 0, 0);
    idle();
    chk("R5 pending after success", pending, 4'b0101);
    chk("R5 full low", full, 1'b0);
    chk("R5 no irq on success", irq, 1'b0);
    step(1, 16'h00E5, 48'h0000_5000_0000, 0, 0, 0, 0);
    step(1, 16'h00F6, 48'h0000_6000_0000, 0, 0, 0, 0);
    idle();
    chk("R3 refill", pending, 4'hF);

    step(0, 0, 0, 1, 2'd2, 1, 0);
    idle();
    err_sel = 2'd2;
    #0.1;
    chk("R6 err_valid", err_valid, 4'b0100);
    chk("R6 irq", irq, 1'b1);
    chk("R6 node", err_node, 16'h00C3);
    chk("R6 offset", err_offset, 48'h1234_5678_9ABC);
    chk("R5 freed by fail", pending, 4'b1011);

    step(1, 16'h0077, 48'h0000_7000_0000, 0, 0, 0, 0);
    step(1, 16'h0088, 48'hABCD_0000_0100, 1, 2'd0, 0, 0);
    idle();
    chk("R9 same slot refreed", pending, 4'hF);
    chk("R9 full kept", full, 1'b1);

    step(0, 0, 0, 1, 2'd2, 1, 0);
    idle();
    chk("R7 ovf", err_ovf, 4'b0100);
    chk("R7 err_valid", err_valid, 4'b0100);
    chk("R7 node kept", err_node, 16'h00C3);
    chk("R7 offset kept", err_offset, 48'h1234_5678_9ABC);

    step(0, 0, 0, 1, 2'd3, 0, 0);
    step(0, 0, 0, 1, 2'd3, 1, 0);
    idle();
    chk("R5 stray cpl err", err_valid, 4'b0100);
    chk("R5 stray cpl pend", pending, 4'b0011);

    post_en = 1'b0;
    step(1, 16'h0099, 48'h0, 0, 0, 0, 0);
    chk("R10 ready low", req_ready, 1'b0);
    idle();
    chk("R10 pending held", pending, 4'b0011);

    step(0, 0, 0, 0, 0, 0, 4'b0100);
    idle();
    chk("R8 err cleared", err_valid, 4'h0);
    chk("R8 ovf cleared", err_ovf, 4'h0);
    chk("R8 irq low", irq, 1'b0);

    post_en = 1'b1;
    step(0, 0, 0, 1, 2'd0, 1, 0);
    idle();
    err_sel = 2'd0;
    #0.1;
    chk("R6 slot0 err", err_valid, 4'b0001);
    chk("R6 slot0 node", err_node, 16'h0088);
    chk("R6 slot0 offset", err_offset, 48'hABCD_0000_0100);
    chk("R6 slot0 irq", irq, 1'b1);

    idle();
    report();
  end
endmodule